// File: doc/BRIEF.md
# Streaming Causal Attention Unit with Online Softmax

This block computes causal single-head attention one query at a time, without ever holding a full score matrix. A query vector of `D` fixed-point elements is loaded first. Then the key/value pairs for positions 0 to `N-1` stream past, one element pair per beat. Each key's dot product with the query is scaled by 1/sqrt(`D`). That score is folded at once into a running maximum, a running exponential sum and a running weighted value vector. The old statistics are rescaled by exp(old max - new max), so the unit never needs a second pass over the keys.

Queries are served from position `N-1` down to position 0, after which the order wraps back to `N-1`. Keys at positions later than the current query are still accepted on the stream, but the masking discards them. Once the last key of a query has been handled, each accumulated output element is divided by the exponential sum in a sequential divider. The result leaves as a `D`-element stream, with a last flag and the query position.

All data uses signed two's complement with `FRAC` fractional bits (4 by default), so a raw value of 16 means 1.0. The exponential comes from a base-2 table. Any argument at or below `-EXP_FLOOR` yields exactly zero.

Top module: `stream_attn`

## Requirements
- R1: After reset, `q_ready` is 1, `kv_ready` is 0, `out_valid` is 0, and `out_pos` reads `N-1`.
- R2: Results come out for query positions `N-1`, `N-2`, and so on down to 0, then again from `N-1`. `out_pos` gives the position of the result on the output.
- R3: A query takes exactly `D` accepted `q` beats. It then takes `N*D` accepted `kv` beats, key-major and with element 0 first. After that the unit emits `D` results with element 0 first, and `out_last` is set only on element `D-1`. While `out_valid` is high and `out_ready` is low, the result, the flag and the position hold steady. At most one of `q_ready`, `kv_ready` and `out_valid` is high at a time.
- R4: Result element e of query i equals sum_j w_j v_j[e] / sum_j w_j, taken over j <= i. Here w_j = exp(s_j - max s) and s_j = (q_i . k_j)/sqrt(D) in real arithmetic. The result is correct to within 0.6 (about 10 raw LSB).
- R5: Keys and values at positions j > i have no effect on the result for query i, whatever their size.
- R6: The result for query position 0 equals its own value vector v_0 exactly.
- R7: If a key's scaled score is below the running maximum by `EXP_FLOOR` or more, its weight is exactly zero. The same holds for the rescale factor of the old statistics when a new maximum exceeds the old one by that amount. So a key that dominates by at least that margin makes the result equal its value vector exactly.
- R8: When all visible keys give the same score, the result is the plain mean of the visible value vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| q_valid | input | 1 | Query element present |
| q_ready | output | 1 | Unit accepts a query element |
| q_data | input | W | Query element, signed, FRAC fractional bits |
| kv_valid | input | 1 | Key/value element pair present |
| kv_ready | output | 1 | Unit accepts a key/value pair |
| k_data | input | W | Key element, signed, FRAC fractional bits |
| v_data | input | W | Value element, signed, FRAC fractional bits |
| out_valid | output | 1 | Result element present |
| out_ready | input | 1 | Downstream accepts the result element |
| out_data | output | W | Result element, signed, FRAC fractional bits |
| out_last | output | 1 | Marks result element D-1 |
| out_pos | output | clog2(N) | Query position of the current result |

## Verification
The cases hardest to reach from the ports are those where the exponential is forced to exactly zero. One is the rescale factor on the very first visible key, where the maximum moves up from the most negative value. The other is a later key whose score beats an earlier one by more than the floor. The bench gets there by sending a query of all-maximum elements against a key 0 of all-minimum elements and then keys of all-maximum elements. The large score gap makes both weights vanish, so positions 0 and 1 must give their own value vectors bit for bit. A separate sweep places keys with very large scores and value vectors of maximum magnitude after each query position, so that any leak through the masking would move the result far outside tolerance.

// File: rtl/stream_attn.sv
`timescale 1ns/1ps
module stream_attn #(
  parameter int N         = 8,
  parameter int D         = 4,
  parameter int W         = 8,
  parameter int FRAC      = 4,
  parameter int EXP_FLOOR = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         q_valid,
  output logic                         q_ready,
  input  logic signed [W-1:0]          q_data,
  input  logic                         kv_valid,
  output logic                         kv_ready,
  input  logic signed [W-1:0]          k_data,
  input  logic signed [W-1:0]          v_data,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic signed [W-1:0]          out_data,
  output logic                         out_last,
  output logic [$clog2(N)-1:0]         out_pos
);

  localparam int LOGD   = $clog2(D);
  localparam int SHIFT  = LOGD / 2;
  localparam int PW     = $clog2(N);
  localparam int EF     = 15;
  localparam int EW     = EF + 1;
  localparam int SW     = 2 * W + LOGD;
  localparam int SW1    = SW + 1;
  localparam int TW     = SW + 10;
  localparam int LW     = EF + 2 + PW;
  localparam int OW     = W + EF + 2 + PW;
  localparam int OCW    = OW + EW + 1;
  localparam int CW     = $clog2(OW + 1);
  localparam int FLOOR_A = EXP_FLOOR << FRAC;
  localparam int MAXMAG = 2 ** (W - 1) - 1;
  localparam logic [LOGD-1:0] LAST_E = LOGD'(D - 1);
  localparam logic [PW-1:0]   LAST_P = PW'(N - 1);
  localparam logic signed [SW-1:0] M_MIN = {1'b1, {(SW-1){1'b0}}};

  typedef enum logic [2:0] {S_Q, S_KV, S_UPD, S_DIV, S_OUT} st_t;
  st_t st;

  logic signed [W-1:0]  q_vec [D];
  logic signed [W-1:0]  v_vec [D];
  logic signed [OW-1:0] o_acc [D];
  logic [LW-1:0]        l_acc;
  logic signed [SW-1:0] m_run, s_reg, acc;
  logic [LOGD-1:0]      idx;
  logic [PW-1:0]        kpos, qpos;
  logic [CW-1:0]        div_cnt;
  logic [OW-1:0]        div_num, div_quo;
  logic [LW:0]          div_rem;
  logic                 div_neg;
  logic signed [W-1:0]  out_reg;

  function automatic logic [EW-1:0] exp_neg(input logic [SW:0] a);
    logic [TW-1:0] t, n;
    logic [EW-1:0] base;
    t = (TW'(a) * TW'(369)) >> 8;
    n = t >> FRAC;
    case (t[FRAC-1 -: 4])
      4'd0:  base = 16'd32768;
      4'd1:  base = 16'd31379;
      4'd2:  base = 16'd30048;
      4'd3:  base = 16'd28774;
      4'd4:  base = 16'd27554;
      4'd5:  base = 16'd26386;
      4'd6:  base = 16'd25268;
      4'd7:  base = 16'd24196;
      4'd8:  base = 16'd23170;
      4'd9:  base = 16'd22188;
      4'd10: base = 16'd21247;
      4'd11: base = 16'd20347;
      4'd12: base = 16'd19484;
      4'd13: base = 16'd18658;
      4'd14: base = 16'd17867;
      default: base = 16'd17109;
    endcase
    if (a >= SW1'(FLOOR_A) || n >= TW'(EW)) return '0;
    return base >> n;
  endfunction

  logic signed [SW-1:0] prod_qk, acc_next, s_next, m_new;
  logic [SW:0]          arg_c, arg_p;
  logic [EW-1:0]        exp_c, exp_p;
  logic signed [OW-1:0] o_sel, pv, o_next, o_abs;
  logic signed [OCW-1:0] oc;
  logic [LW+EW-1:0]     lc;
  logic [LW-1:0]        l_next;
  logic [LW:0]          rem_sh, rem_nx;
  logic                 ge;
  logic [OW-1:0]        quo_nx;
  logic [W-1:0]         sat;

  assign prod_qk  = SW'(q_vec[idx]) * SW'(k_data);
  assign acc_next = acc + prod_qk;
  assign s_next   = acc_next >>> (FRAC + SHIFT);
  assign m_new    = (s_reg > m_run) ? s_reg : m_run;
  assign arg_c    = SW1'(m_new) - SW1'(m_run);
  assign arg_p    = SW1'(m_new) - SW1'(s_reg);
  assign exp_c    = exp_neg(arg_c);
  assign exp_p    = exp_neg(arg_p);

  assign o_sel  = o_acc[idx];
  assign oc     = OCW'(o_sel) * OCW'($signed({1'b0, exp_c}));
  assign pv     = OW'($signed({1'b0, exp_p})) * OW'(v_vec[idx]);
  assign o_next = $signed(oc[OW+EF-1:EF]) + pv;
  assign lc     = (LW+EW)'(l_acc) * (LW+EW)'(exp_c);
  assign l_next = lc[LW+EF-1:EF] + LW'(exp_p);

  assign o_abs  = o_sel[OW-1] ? -o_sel : o_sel;
  assign rem_sh = {div_rem[LW-1:0], div_num[OW-1]};
  assign ge     = rem_sh >= {1'b0, l_acc};
  assign rem_nx = ge ? rem_sh - {1'b0, l_acc} : rem_sh;
  assign quo_nx = {div_quo[OW-2:0], ge};
  assign sat    = (quo_nx > OW'(MAXMAG)) ? W'(MAXMAG) : quo_nx[W-1:0];

  assign q_ready   = (st == S_Q);
  assign kv_ready  = (st == S_KV);
  assign out_valid = (st == S_OUT);
  assign out_data  = out_reg;
  assign out_last  = out_valid && (idx == LAST_E);
  assign out_pos   = qpos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_Q;
      idx     <= '0;
      kpos    <= '0;
      qpos    <= LAST_P;
      acc     <= '0;
      s_reg   <= '0;
      m_run   <= M_MIN;
      l_acc   <= '0;
      div_cnt <= '0;
      div_num <= '0;
      div_quo <= '0;
      div_rem <= '0;
      div_neg <= 1'b0;
      out_reg <= '0;
      for (int e = 0; e < D; e++) begin
        q_vec[e] <= '0;
        v_vec[e] <= '0;
        o_acc[e] <= '0;
      end
    end else begin
      case (st)
        S_Q: if (q_valid) begin
          q_vec[idx] <= q_data;
          if (idx == LAST_E) begin
            idx  <= '0;
            kpos <= '0;
            acc  <= '0;
            st   <= S_KV;
          end else idx <= idx + 1'b1;
        end
        S_KV: if (kv_valid) begin
          v_vec[idx] <= v_data;
          if (idx == LAST_E) begin
            idx <= '0;
            acc <= '0;
            if (kpos <= qpos) begin
              s_reg <= s_next;
              st    <= S_UPD;
            end else if (kpos == LAST_P) begin
              div_cnt <= '0;
              st      <= S_DIV;
            end else kpos <= kpos + 1'b1;
          end else begin
            idx <= idx + 1'b1;
            acc <= acc_next;
          end
        end
        S_UPD: begin
          o_acc[idx] <= o_next;
          if (idx == LAST_E) begin
            l_acc <= l_next;
            m_run <= m_new;
            idx   <= '0;
            if (kpos == LAST_P) begin
              div_cnt <= '0;
              st      <= S_DIV;
            end else begin
              kpos <= kpos + 1'b1;
              st   <= S_KV;
            end
          end else idx <= idx + 1'b1;
        end
        S_DIV: begin
          if (div_cnt == '0) begin
            div_num <= o_abs;
            div_neg <= o_sel[OW-1];
            div_rem <= '0;
            div_quo <= '0;
            div_cnt <= 1'b1;
          end else begin
            div_rem <= rem_nx;
            div_num <= {div_num[OW-2:0], 1'b0};
            div_quo <= quo_nx;
            if (div_cnt == CW'(OW)) begin
              out_reg <= div_neg ? -sat : sat;
              st      <= S_OUT;
            end else div_cnt <= div_cnt + 1'b1;
          end
        end
        default: if (out_ready) begin
          if (idx == LAST_E) begin
            idx   <= '0;
            m_run <= M_MIN;
            l_acc <= '0;
            for (int e = 0; e < D; e++) o_acc[e] <= '0;
            qpos  <= (qpos == '0) ? LAST_P : qpos - 1'b1;
            st    <= S_Q;
          end else begin
            idx     <= idx + 1'b1;
            div_cnt <= '0;
            st      <= S_DIV;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/stream_attn_chk.sv
`timescale 1ns/1ps
module stream_attn_chk #(
  parameter int N  = 8,
  parameter int W  = 8,
  parameter int LW = 20
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 q_ready,
  input logic                 kv_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [W-1:0]         out_data,
  input logic                 out_last,
  input logic [$clog2(N)-1:0] out_pos,
  input logic [LW-1:0]        l_acc
);
  localparam int PW = $clog2(N);

  assert_one_channel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({q_ready, kv_ready, out_valid}));

  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last) && $stable(out_pos));

  assert_last_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_sum_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> l_acc != '0);

  assert_reverse_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=>
      out_pos == (($past(out_pos) == '0) ? PW'(N - 1) : $past(out_pos) - 1'b1));
endmodule

bind stream_attn stream_attn_chk #(.N(N), .W(W), .LW(LW)) chk_i (
  .clk(clk), .rst_n(rst_n), .q_ready(q_ready), .kv_ready(kv_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last), .out_pos(out_pos), .l_acc(l_acc)
);

// File: tb/stream_attn_tb_top.sv
`timescale 1ns/1ps
module stream_attn_tb_top;
  localparam int N = 8, D = 4, W = 8, FRAC = 4;
  localparam real TOL = 0.6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic q_valid = 1'b0, kv_valid = 1'b0, out_ready = 1'b1;
  logic signed [W-1:0] q_data = '0, k_data = '0, v_data = '0;
  logic q_ready, kv_ready, out_valid, out_last;
  logic signed [W-1:0] out_data;
  logic [$clog2(N)-1:0] out_pos;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stream_attn #(.N(N), .D(D), .W(W), .FRAC(FRAC), .EXP_FLOOR(12)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .q_valid(q_valid), .q_ready(q_ready), .q_data(q_data),
    .kv_valid(kv_valid), .kv_ready(kv_ready), .k_data(k_data), .v_data(v_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_pos(out_pos));

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int qv(int p, int i, int e);
    if (p == 2) return 127;
    return ((i * 37 + e * 11 + p * 53 + 7) % 64) - 32;
  endfunction

  function automatic int kv(int p, int i, int j, int e);
    case (p)
      1: return ((e * 19 + 5) % 64) - 32;
      2: return (j == 0) ? -128 : 127;
      3: if (j > i) return (qv(p, i, e) >= 0) ? 127 : -128;
      default: ;
    endcase
    return ((j * 23 + e * 41 + p * 7 + 1) % 64) - 32;
  endfunction

  function automatic int vv(int p, int i, int j, int e);
    if (p == 3 && j > i) return 127;
    return ((j * 29 + e * 17 + p * 13 + 3) % 128) - 64;
  endfunction

  function automatic real model(int p, int i, int e);
    real s [N];
    real mx, num, den, w;
    mx = -1.0e30;
    for (int j = 0; j <= i; j++) begin
      s[j] = 0.0;
      for (int x = 0; x < D; x++) s[j] += qv(p, i, x) * kv(p, i, j, x) / 256.0;
      s[j] = s[j] / $sqrt(D);
      if (s[j] > mx) mx = s[j];
    end
    num = 0.0; den = 0.0;
    for (int j = 0; j <= i; j++) begin
      w = $exp(s[j] - mx);
      num += w * vv(p, i, j, e) / 16.0;
      den += w;
    end
    return num / den;
  endfunction

  task automatic run_query(input int p, input int i);
    for (int e = 0; e < D; e++) begin
      q_data = W'(qv(p, i, e)); q_valid = 1'b1;
      while (!q_ready) @(negedge clk);
      @(negedge clk);
    end
    q_valid = 1'b0;
    for (int j = 0; j < N; j++)
      for (int e = 0; e < D; e++) begin
        k_data = W'(kv(p, i, j, e)); v_data = W'(vv(p, i, j, e)); kv_valid = 1'b1;
        while (!kv_ready) @(negedge clk);
        @(negedge clk);
      end
    kv_valid = 1'b0;
    for (int e = 0; e < D; e++) begin
      int act, ex;
      real r;
      if (e == 1) out_ready = 1'b0;
      while (!out_valid) @(negedge clk);
      act = int'(out_data);
      check(out_pos == i, "R2 position", int'(out_pos), i);
      check(out_last == (e == D - 1), "R3 last flag", int'(out_last), int'(e == D - 1));
      if (e == 1) begin
        repeat (3) @(negedge clk);
        check(out_valid && int'(out_data) == act, "R3 hold under stall", int'(out_data), act);
        out_ready = 1'b1;
      end
      r = model(p, i, e);
      ex = $rtoi(r * 16.0 + (r >= 0 ? 0.5 : -0.5));
      if (i == 0)
        check(act == vv(p, 0, 0, e), "R6 position zero", act, vv(p, 0, 0, e));
      else if (p == 2 && i == 1)
        check(act == vv(p, 1, 1, e), "R7 floored weight", act, vv(p, 1, 1, e));
      else if (p == 1)
        check((act / 16.0 - r) < TOL && (r - act / 16.0) < TOL, "R8 uniform mean", act, ex);
      else if (p == 3)
        check((act / 16.0 - r) < TOL && (r - act / 16.0) < TOL, "R5 masked future", act, ex);
      else
        check((act / 16.0 - r) < TOL && (r - act / 16.0) < TOL, "R4 softmax result", act, ex);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(q_ready == 1'b1, "R1 q_ready", int'(q_ready), 1);
    check(kv_ready == 1'b0, "R1 kv_ready", int'(kv_ready), 0);
    check(out_pos == N - 1, "R1 out_pos", int'(out_pos), N - 1);
    for (int p = 0; p < 4; p++)
      for (int i = N - 1; i >= 0; i--) run_query(p, i);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule